// File: doc/BRIEF.md
# Cache Line Burst Fill Engine

This block services one cache miss at a time. A miss request carries a byte address. The engine clears the six line-offset bits to get the base of the naturally aligned 64-byte line. It then sends one read command to a memory channel that has a 64-bit data path. The command carries the line base and the index of the 8-byte chunk that holds the requested byte, and no per-beat address follows it.

The memory answers with eight beats. The first beat is the requested chunk, and the order then wraps from chunk 7 back to chunk 0. The engine drops each beat into its home slot of a line buffer. The first beat also goes out to the load path in the cycle it arrives, together with the byte offset inside that chunk, so the consumer does not wait for the rest of the line. After the eighth beat, the whole line goes to the cache data array in a single handshake. A new request is accepted only after that handshake.

Top module: `line_fill_engine`

## Requirements
- R1: While reset is active, and once it is released, the engine idles: req_ready is 1, and mem_cmd_valid, fwd_valid and arr_wr_valid are 0.
- R2: The cycle after a request is accepted, mem_cmd_valid rises with mem_cmd_addr equal to req_addr with bits [5:0] cleared and mem_cmd_first equal to req_addr[5:3]. Both are held stable until mem_cmd_ready is seen.
- R3: Each miss produces exactly one command handshake. mem_cmd_valid drops in the cycle after mem_cmd_ready.
- R4: Beat k of the burst (k = 0..7, counting only cycles with mem_rsp_valid high) is stored into slot (mem_cmd_first + k) mod 8. Slot s occupies bits [64*s+63 : 64*s] of arr_wr_line.
- R5: fwd_valid is 1 only in the cycle of the first beat of a burst. In that cycle fwd_data equals mem_rsp_data and fwd_byte_ofs equals req_addr[2:0].
- R6: The cycle after the eighth beat, arr_wr_valid rises with arr_wr_addr equal to the line base and arr_wr_line holding all eight slots. Address and line stay stable until arr_wr_ready.
- R7: From request acceptance until the array write handshake, req_ready is 0 and req_valid is ignored. req_ready is 1 again in the cycle after the handshake.
- R8: A mem_rsp_valid pulse while no burst is being collected (command not yet accepted, or line already complete) alters neither the line nor fwd_valid.
- R9: Beats may arrive with idle cycles between them. Only cycles with mem_rsp_valid high advance the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Engine idle and able to take a miss |
| req_addr | input | ADDR_W | Byte address of the missing load |
| mem_cmd_valid | output | 1 | Burst read command present |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_addr | output | ADDR_W | Line-aligned base address |
| mem_cmd_first | output | CHUNK_W | Chunk index the burst starts at |
| mem_rsp_valid | input | 1 | Beat strobe |
| mem_rsp_data | input | BEAT_W | Beat data |
| fwd_valid | output | 1 | Early critical-chunk forward |
| fwd_data | output | BEAT_W | Critical chunk |
| fwd_byte_ofs | output | BYTE_W | Requested byte inside the chunk |
| arr_wr_valid | output | 1 | Full line write to cache array |
| arr_wr_ready | input | 1 | Array takes the line |
| arr_wr_addr | output | ADDR_W | Line base address for the write |
| arr_wr_line | output | LINE_W | Assembled line, slot s at bits 64*s upward |

## Verification
The fill is exercised with one directed miss per start chunk 0 through 7, with back-to-back beats. A wrong rotation or a slot error then shows up as a misplaced 64-bit slot whose pattern encodes its chunk number. Random misses add stalled command acceptance, random gaps between beats and a delayed array handshake. These separate the beat counter from the clock and the forward from later beats. Stray beat strobes and competing requests are injected while the engine is busy. They show whether the line or the ready signal can be disturbed outside the burst window.

// File: rtl/lfe_pkg.sv
package lfe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_BEATS = 2'd2,
    ST_WRITE = 2'd3
  } fill_state_e;
endpackage

// File: rtl/lfe_rst_sync.sv
// Asynchronous assertion, synchronous release of an active-low reset.
module lfe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[i] <= 1'b0;
        end else begin
          if (i == 0) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lfe_ctrl.sv
// Fill sequencer: request capture, command issue, beat counting, array write.
module lfe_ctrl
  import lfe_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CHUNK_W    = 3,
  parameter int BYTE_W     = 3,
  parameter int LINE_OFS_W = CHUNK_W + BYTE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         req_ready,
  input  logic                         mem_cmd_ready,
  output logic                         mem_cmd_valid,
  input  logic                         mem_rsp_valid,
  input  logic                         arr_wr_ready,
  output logic                         arr_wr_valid,
  output logic [ADDR_W-LINE_OFS_W-1:0] line_base,
  output logic [CHUNK_W-1:0]           first_chunk,
  output logic [BYTE_W-1:0]            byte_ofs,
  output logic                         beat_take,
  output logic [CHUNK_W-1:0]           beat_slot,
  output logic                         beat_first
);
  localparam logic [CHUNK_W-1:0] LAST_BEAT = '1;

  fill_state_e         state_q, state_d;
  logic [CHUNK_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0]   addr_q;
  logic                addr_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_CMD;
          cnt_d   = '0;
          addr_en = 1'b1;
        end
      end
      ST_CMD: begin
        if (mem_cmd_ready) state_d = ST_BEATS;
      end
      ST_BEATS: begin
        if (mem_rsp_valid) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BEAT) state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (arr_wr_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // captured miss address, enabled on acceptance only
  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= req_addr;
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_cmd_valid = (state_q == ST_CMD);
  assign arr_wr_valid  = (state_q == ST_WRITE);
  assign line_base     = addr_q[ADDR_W-1:LINE_OFS_W];
  assign first_chunk   = addr_q[LINE_OFS_W-1:BYTE_W];
  assign byte_ofs      = addr_q[BYTE_W-1:0];
  assign beat_take     = (state_q == ST_BEATS) && mem_rsp_valid;
  assign beat_slot     = first_chunk + cnt_q;   // wraps modulo line beats
  assign beat_first    = beat_take && (cnt_q == '0);
endmodule

// File: rtl/lfe_line_buf.sv
// Line buffer: one register per chunk slot, written at its home position.
module lfe_line_buf #(
  parameter int BEAT_W  = 64,
  parameter int BEATS   = 8,
  parameter int CHUNK_W = $clog2(BEATS),
  parameter int LINE_W  = BEAT_W * BEATS
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [CHUNK_W-1:0] wr_slot,
  input  logic [BEAT_W-1:0]  wr_data,
  output logic [LINE_W-1:0]  line
);
  generate
    for (genvar s = 0; s < BEATS; s++) begin : g_slot
      logic [BEAT_W-1:0] slot_q;
      logic              slot_en;

      assign slot_en = wr_en && (wr_slot == CHUNK_W'(s));

      always_ff @(posedge clk) begin
        if (slot_en) slot_q <= wr_data;
      end

      assign line[s*BEAT_W +: BEAT_W] = slot_q;
    end
  endgenerate
endmodule

// File: rtl/line_fill_engine.sv
module line_fill_engine #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_W     = 64,
  parameter int BEATS      = 8,
  parameter int RST_STAGES = 2,
  localparam int BYTE_W     = $clog2(BEAT_W / 8),
  localparam int CHUNK_W    = $clog2(BEATS),
  localparam int LINE_OFS_W = BYTE_W + CHUNK_W,
  localparam int LINE_W     = BEAT_W * BEATS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               mem_cmd_valid,
  input  logic               mem_cmd_ready,
  output logic [ADDR_W-1:0]  mem_cmd_addr,
  output logic [CHUNK_W-1:0] mem_cmd_first,
  input  logic               mem_rsp_valid,
  input  logic [BEAT_W-1:0]  mem_rsp_data,
  output logic               fwd_valid,
  output logic [BEAT_W-1:0]  fwd_data,
  output logic [BYTE_W-1:0]  fwd_byte_ofs,
  output logic               arr_wr_valid,
  input  logic               arr_wr_ready,
  output logic [ADDR_W-1:0]  arr_wr_addr,
  output logic [LINE_W-1:0]  arr_wr_line
);
  logic                         rst_n_int;
  logic [ADDR_W-LINE_OFS_W-1:0] line_base;
  logic [CHUNK_W-1:0]           first_chunk;
  logic [BYTE_W-1:0]            byte_ofs;
  logic                         beat_take;
  logic [CHUNK_W-1:0]           beat_slot;
  logic                         beat_first;

  lfe_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lfe_ctrl #(
    .ADDR_W     (ADDR_W),
    .CHUNK_W    (CHUNK_W),
    .BYTE_W     (BYTE_W),
    .LINE_OFS_W (LINE_OFS_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_ready     (req_ready),
    .mem_cmd_ready (mem_cmd_ready),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .arr_wr_ready  (arr_wr_ready),
    .arr_wr_valid  (arr_wr_valid),
    .line_base     (line_base),
    .first_chunk   (first_chunk),
    .byte_ofs      (byte_ofs),
    .beat_take     (beat_take),
    .beat_slot     (beat_slot),
    .beat_first    (beat_first)
  );

  lfe_line_buf #(
    .BEAT_W  (BEAT_W),
    .BEATS   (BEATS),
    .CHUNK_W (CHUNK_W),
    .LINE_W  (LINE_W)
  ) u_buf (
    .clk     (clk),
    .wr_en   (beat_take),
    .wr_slot (beat_slot),
    .wr_data (mem_rsp_data),
    .line    (arr_wr_line)
  );

  assign mem_cmd_addr  = {line_base, {LINE_OFS_W{1'b0}}};
  assign mem_cmd_first = first_chunk;
  assign arr_wr_addr   = {line_base, {LINE_OFS_W{1'b0}}};

  // critical chunk bypasses the buffer in its arrival cycle
  assign fwd_valid     = beat_first;
  assign fwd_data      = mem_rsp_data;
  assign fwd_byte_ofs  = byte_ofs;
endmodule

// File: rtl/lfe_checker.sv
module lfe_checker #(
  parameter int ADDR_W  = 32,
  parameter int CHUNK_W = 3,
  parameter int LINE_W  = 512
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               mem_cmd_valid,
  input logic               mem_cmd_ready,
  input logic [ADDR_W-1:0]  mem_cmd_addr,
  input logic [CHUNK_W-1:0] mem_cmd_first,
  input logic               mem_rsp_valid,
  input logic               fwd_valid,
  input logic               arr_wr_valid,
  input logic               arr_wr_ready,
  input logic [ADDR_W-1:0]  arr_wr_addr,
  input logic [LINE_W-1:0]  arr_wr_line
);
  a_r2_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=>
      mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_first));

  a_r3_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && mem_cmd_ready |=> !mem_cmd_valid);

  a_r5_fwd_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> mem_rsp_valid && !mem_cmd_valid && !arr_wr_valid);

  a_r6_wr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_valid && !arr_wr_ready |=>
      arr_wr_valid && $stable(arr_wr_addr) && $stable(arr_wr_line));

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid || arr_wr_valid) |-> !req_ready);

  a_r7_ready_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_valid && arr_wr_ready |=> !arr_wr_valid && req_ready);
endmodule

bind line_fill_engine lfe_checker #(
  .ADDR_W  (ADDR_W),
  .CHUNK_W (CHUNK_W),
  .LINE_W  (LINE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_cmd_valid (mem_cmd_valid),
  .mem_cmd_ready (mem_cmd_ready),
  .mem_cmd_addr  (mem_cmd_addr),
  .mem_cmd_first (mem_cmd_first),
  .mem_rsp_valid (mem_rsp_valid),
  .fwd_valid     (fwd_valid),
  .arr_wr_valid  (arr_wr_valid),
  .arr_wr_ready  (arr_wr_ready),
  .arr_wr_addr   (arr_wr_addr),
  .arr_wr_line   (arr_wr_line)
);

// File: tb/sim_line_fill_engine.sv
`timescale 1ns/1ps
module sim_line_fill_engine;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready;
  logic [31:0]  req_addr;
  logic         mem_cmd_valid, mem_cmd_ready;
  logic [31:0]  mem_cmd_addr;
  logic [2:0]   mem_cmd_first;
  logic         mem_rsp_valid;
  logic [63:0]  mem_rsp_data;
  logic         fwd_valid;
  logic [63:0]  fwd_data;
  logic [2:0]   fwd_byte_ofs;
  logic         arr_wr_valid, arr_wr_ready;
  logic [31:0]  arr_wr_addr;
  logic [511:0] arr_wr_line;

  int checks = 0;
  int fails  = 0;
  int cmd_count = 0;

  always #5 clk = ~clk;

  line_fill_engine u0 (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
    .mem_cmd_valid (mem_cmd_valid), .mem_cmd_ready (mem_cmd_ready),
    .mem_cmd_addr (mem_cmd_addr), .mem_cmd_first (mem_cmd_first),
    .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data),
    .fwd_valid (fwd_valid), .fwd_data (fwd_data), .fwd_byte_ofs (fwd_byte_ofs),
    .arr_wr_valid (arr_wr_valid), .arr_wr_ready (arr_wr_ready),
    .arr_wr_addr (arr_wr_addr), .arr_wr_line (arr_wr_line)
  );

  always @(posedge clk) if (mem_cmd_valid && mem_cmd_ready) cmd_count++;

  function automatic logic [63:0] mem_word(input logic [31:0] base, input logic [2:0] c);
    return {base, 16'hBEEF, 13'h0, c};
  endfunction

  function automatic logic [511:0] exp_line_of(input logic [31:0] base);
    logic [511:0] l;
    for (int s = 0; s < 8; s++) l[64*s +: 64] = mem_word(base, 3'(s));
    return l;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_miss(input logic [31:0] addr, input int cmd_wait,
                         input int gap_max, input int wr_wait);
    logic [31:0]  base;
    logic [2:0]   first;
    logic [511:0] exp_line;
    int           cmds0;
    base     = {addr[31:6], 6'b0};
    first    = addr[5:3];
    exp_line = exp_line_of(base);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = addr;
    cmds0 = cmd_count;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (cmd_wait) begin
      #1;
      check("R2 cmd valid", mem_cmd_valid, 1);
      check("R2 cmd addr", mem_cmd_addr, base);
      check("R7 busy ready", req_ready, 0);
      // competing request and stray beat while command pending
      req_valid = 1'b1; req_addr = ~addr;
      mem_rsp_valid = 1'b1; mem_rsp_data = 64'hDEAD_DEAD_DEAD_DEAD;
      #1;
      check("R8 stray no fwd", fwd_valid, 0);
      @(negedge clk);
      req_valid = 1'b0; mem_rsp_valid = 1'b0;
    end
    #1;
    check("R2 cmd valid", mem_cmd_valid, 1);
    check("R2 cmd addr", mem_cmd_addr, base);
    check("R2 cmd first", mem_cmd_first, first);
    mem_cmd_ready = 1'b1;
    @(negedge clk);
    mem_cmd_ready = 1'b0;
    #1;
    check("R3 cmd dropped", mem_cmd_valid, 0);
    for (int k = 0; k < 8; k++) begin
      int gap;
      logic [2:0] slot;
      gap  = (gap_max > 0) ? int'($urandom_range(gap_max, 0)) : 0;
      repeat (gap) begin
        #1;
        check("R9 idle gap no fwd", fwd_valid, 0);
        check("R9 no early write", arr_wr_valid, 0);
        @(negedge clk);
      end
      slot = first + 3'(k);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(base, slot);
      #1;
      check("R5 fwd only first beat", fwd_valid, (k == 0));
      if (k == 0) begin
        check("R5 fwd data", fwd_data, mem_word(base, first));
        check("R5 fwd byte ofs", fwd_byte_ofs, addr[2:0]);
      end
      @(negedge clk);
      mem_rsp_valid = 1'b0;
    end
    #1;
    check("R6 write valid", arr_wr_valid, 1);
    check("R6 write addr", arr_wr_addr, base);
    check("R4 line wrap placement", arr_wr_line, exp_line);
    check("R7 ready low in write", req_ready, 0);
    repeat (wr_wait) begin
      mem_rsp_valid = 1'b1; mem_rsp_data = 64'hBAD0_BAD0_BAD0_BAD0;
      req_valid = 1'b1; req_addr = addr ^ 32'h40;
      @(negedge clk);
      mem_rsp_valid = 1'b0; req_valid = 1'b0;
      #1;
      check("R8 line untouched", arr_wr_line, exp_line);
      check("R6 write held", arr_wr_valid, 1);
    end
    arr_wr_ready = 1'b1;
    @(negedge clk);
    arr_wr_ready = 1'b0;
    #1;
    check("R6 write done", arr_wr_valid, 0);
    check("R7 ready again", req_ready, 1);
    check("R3 one command", cmd_count - cmds0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0;
    mem_cmd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    arr_wr_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset ready", req_ready, 1);
    check("R1 reset cmd", mem_cmd_valid, 0);
    check("R1 reset wr", arr_wr_valid, 0);
    check("R1 reset fwd", fwd_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after release", req_ready, 1);
    check("R1 no cmd after release", mem_cmd_valid, 0);

    // directed: every start chunk, back-to-back beats
    for (int c = 0; c < 8; c++)
      do_miss(32'h0001_2000 + 32'(c * 64) + 32'(c * 8) + 32'(7 - c), 0, 0, 0);
    // directed: stalled command and array, gaps
    do_miss(32'hFFFF_FFFF, 2, 2, 2);
    do_miss(32'h0000_0000, 1, 3, 1);

    // random
    for (int i = 0; i < 40; i++)
      do_miss($urandom, int'($urandom_range(2, 0)), 3, int'($urandom_range(2, 0)));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule